// File: doc/BRIEF.md
# Programmable Per-Channel Edge Detector Bank

This block monitors a wide bus of input signals, up to 256 channels by default. Every channel has its own edge detector. Each detector can be set to report a rising transition, a falling transition, any transition, or nothing. Each channel also has a mask bit that silences its event. The block drives a per-channel event vector and a combined flag that is high whenever any channel reports an event.

Configuration uses a simple write port and a combinational read port.

- **Packed words:** software can write the 2-bit detector codes sixteen channels at a time through control words, and the mask bits thirty-two channels at a time through mask words. Both kinds of word read back as written.
- **Single channel:** software can also program one channel on its own. It first writes a channel number. A later control-value or mask-value write then lands on that channel only. A two-state sequencer tracks whether a channel number has been written.
  - In state `ST_NO_IDX`, no channel number is held. An index write takes the transition `idx_written` to `ST_IDX_SET`.
  - In `ST_IDX_SET`, single-channel writes are applied. Further index writes stay in this state. A dataset clear takes the transition `dataset_cleared` back to `ST_NO_IDX`.
- **Dataset clear:** a clear command returns all configuration and the sample history to zero.

Top module: `edge_watch_bank`

## Requirements
- R1: After reset, every control word, every mask word and the channel index read back as zero. No event is reported until two input samples have been taken.
- R2: A channel with detector code 00 reports an event for exactly one cycle. The event appears in the cycle after the rising clock edge that first captures its input at 1 when the previous captured value was 0.
- R3: A channel with detector code 01 reports a one-cycle event when its captured input goes from 1 to 0, and none on a rise.
- R4: A channel with detector code 10 reports a one-cycle event on both a rise and a fall of its captured input.
- R5: A channel with detector code 11 never reports an event.
- R6: A channel whose mask bit is 1 reports no event, whatever its detector code.
- R7: Control word k is at write/read address k (0 to 15). Channel 16k+j occupies bits [2j+1:2j] of that word.
- R8: Mask word k is at address 16+k (16 to 23). Channel 32k+j occupies bit j of that word.
- R9: Address 24 holds the channel index, taken from data bits [7:0]. After an index write:
  - a write to address 25 sets the indexed channel's code from data bits [1:0];
  - a write to address 26 sets its mask from data bit 0;
  - addresses 25 and 26 read back the indexed channel's code and mask;
  - no other channel changes.
- R10: Writes to addresses 25 and 26 made before any index write since the last reset or clear are ignored.
- R11: A write to address 27 with data bit 0 set clears all control words, mask words, the index and the sample history. No event is reported in the two cycles after the clear, even if the input changed at the same time.
- R12: The combined flag is high exactly when at least one bit of the event vector is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Write address |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 6 | Read address |
| cfg_rdata | output | 32 | Read data (combinational) |
| din | input | NUM_CH | Monitored signals |
| evt_vec | output | NUM_CH | Per-channel event flags |
| evt_any | output | 1 | OR of all event flags |

## Verification
The bench mixes all four detector codes inside one control word and then drives full-bus rises and falls. A design that swapped the code meanings, or packed fields at the wrong bit offsets, flags the wrong channels. Index-then-value writes go to channels deep in the middle words. This catches a sequencer that writes the wrong word, disturbs neighbouring channels, or accepts a value before any index was written. A clear is issued while the inputs change in the same cycle. A detector that compared against the cleared history without priming would raise a false event on every channel.

// File: rtl/edge_watch_pkg.sv
package edge_watch_pkg;

    typedef enum logic [1:0] {
        DET_RISE = 2'b00,
        DET_FALL = 2'b01,
        DET_BOTH = 2'b10,
        DET_OFF  = 2'b11
    } det_mode_e;

    typedef enum logic {
        ST_NO_IDX  = 1'b0,
        ST_IDX_SET = 1'b1
    } sel_state_e;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL0    = 6'd0;
    localparam logic [ADDR_W-1:0] A_MASK0    = 6'd16;
    localparam logic [ADDR_W-1:0] A_IDX      = 6'd24;
    localparam logic [ADDR_W-1:0] A_SEL_CTRL = 6'd25;
    localparam logic [ADDR_W-1:0] A_SEL_MASK = 6'd26;
    localparam logic [ADDR_W-1:0] A_CLEAR    = 6'd27;

    function automatic logic edge_hit(det_mode_e m, logic cur, logic prev);
        logic hit;
        unique case (m)
            DET_RISE: hit = cur & ~prev;
            DET_FALL: hit = ~cur & prev;
            DET_BOTH: hit = cur ^ prev;
            DET_OFF:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
    import edge_watch_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [ADDR_W-1:0]     raddr,
    output logic [DATA_W-1:0]     rdata,
    output logic [2*NUM_CH-1:0]   ctrl_flat,
    output logic [NUM_CH-1:0]     mask_flat,
    output logic                  clear_o
);

    localparam int FIELDS     = DATA_W / 2;
    localparam int CTRL_WORDS = NUM_CH / FIELDS;
    localparam int MASK_WORDS = NUM_CH / DATA_W;
    localparam int IDX_W      = $clog2(NUM_CH);

    sel_state_e              state_q, state_d;
    logic [2*NUM_CH-1:0]     ctrl_q;
    logic [NUM_CH-1:0]       mask_q;
    logic [IDX_W-1:0]        idx_q;
    logic                    idx_wr, clear_wr, sel_ok;

    assign idx_wr   = we && (addr == A_IDX);
    assign clear_wr = we && (addr == A_CLEAR) && wdata[0];

    // next-state process of the index sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NO_IDX:  if (idx_wr)   state_d = ST_IDX_SET;
            ST_IDX_SET: if (clear_wr) state_d = ST_NO_IDX;
        endcase
    end

    // output process of the index sequencer
    always_comb begin
        sel_ok = 1'b0;
        unique case (state_q)
            ST_NO_IDX:  sel_ok = 1'b0;
            ST_IDX_SET: sel_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NO_IDX;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_wr) begin
            ctrl_q <= '0;
            mask_q <= '0;
            idx_q  <= '0;
        end else if (we) begin
            for (int k = 0; k < CTRL_WORDS; k++)
                if (addr == ADDR_W'(int'(A_CTRL0) + k))
                    ctrl_q[k*DATA_W +: DATA_W] <= wdata;
            for (int k = 0; k < MASK_WORDS; k++)
                if (addr == ADDR_W'(int'(A_MASK0) + k))
                    mask_q[k*DATA_W +: DATA_W] <= wdata;
            if (addr == A_IDX)
                idx_q <= wdata[IDX_W-1:0];
            if (addr == A_SEL_CTRL && sel_ok)
                ctrl_q[{idx_q, 1'b0} +: 2] <= wdata[1:0];
            if (addr == A_SEL_MASK && sel_ok)
                mask_q[idx_q] <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < CTRL_WORDS; k++)
            if (raddr == ADDR_W'(int'(A_CTRL0) + k))
                rdata = ctrl_q[k*DATA_W +: DATA_W];
        for (int k = 0; k < MASK_WORDS; k++)
            if (raddr == ADDR_W'(int'(A_MASK0) + k))
                rdata = mask_q[k*DATA_W +: DATA_W];
        if (raddr == A_IDX)      rdata = DATA_W'(idx_q);
        if (raddr == A_SEL_CTRL) rdata = DATA_W'(ctrl_q[{idx_q, 1'b0} +: 2]);
        if (raddr == A_SEL_MASK) rdata = DATA_W'(mask_q[idx_q]);
    end

    assign ctrl_flat = ctrl_q;
    assign mask_flat = mask_q;
    assign clear_o   = clear_wr;

    assert_no_idx_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NO_IDX && we && (addr == A_SEL_CTRL || addr == A_SEL_MASK))
        |=> ($stable(ctrl_q) && $stable(mask_q)));

    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> (ctrl_q == '0 && mask_q == '0 && state_q == ST_NO_IDX));

    assert_idx_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (state_q == ST_IDX_SET));

endmodule

// File: rtl/edge_chan.sv
module edge_chan
    import edge_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       armed,
    input  logic       din,
    input  logic [1:0] mode,
    input  logic       mask,
    output logic       evt
);

    logic s_cur, s_prev;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s_cur  <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_cur  <= din;
            s_prev <= s_cur;
        end
    end

    assign evt = armed && !mask && edge_hit(det_mode_e'(mode), s_cur, s_prev);

    assert_evt_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> ($past(din) != $past(din, 2)));

    assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode == DET_RISE) |-> ($past(din) && !$past(din, 2)));

    assert_fall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode == DET_FALL) |-> (!$past(din) && $past(din, 2)));

    assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_OFF) |-> !evt);

    assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !evt);

endmodule

// File: rtl/edge_watch_bank.sv
module edge_watch_bank
    import edge_watch_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [5:0]        cfg_raddr,
    output logic [31:0]       cfg_rdata,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] evt_vec,
    output logic              evt_any
);

    logic [2*NUM_CH-1:0] ctrl_flat;
    logic [NUM_CH-1:0]   mask_flat;
    logic                clear_p;
    logic                v_cur, v_prev;

    edge_cfg_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .raddr     (cfg_raddr),
        .rdata     (cfg_rdata),
        .ctrl_flat (ctrl_flat),
        .mask_flat (mask_flat),
        .clear_o   (clear_p)
    );

    // history priming: events need two samples since reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear_p) begin
            v_cur  <= 1'b0;
            v_prev <= 1'b0;
        end else begin
            v_cur  <= 1'b1;
            v_prev <= v_cur;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        edge_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear_p),
            .armed (v_prev),
            .din   (din[i]),
            .mode  (ctrl_flat[2*i +: 2]),
            .mask  (mask_flat[i]),
            .evt   (evt_vec[i])
        );
    end

    assign evt_any = |evt_vec;

    assert_quiet_after_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_CLEAR && cfg_wdata[0]) |=> !evt_any);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_cur) |-> (evt_vec == '0));

endmodule

// File: tb/edge_watch_bank_bench.sv
`timescale 1ns/1ps
module edge_watch_bank_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [5:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [5:0]   cfg_raddr = '0;
    logic [31:0]  cfg_rdata;
    logic [255:0] din = '0;
    logic [255:0] evt_vec;
    logic         evt_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_watch_bank u_edge_watch_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .din(din), .evt_vec(evt_vec), .evt_any(evt_any)
    );

    task automatic check_vec(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_evt(string tag, logic [255:0] exp);
        check_vec(tag, evt_vec, exp);
        check_vec({tag, " R12 any"}, {255'd0, evt_any}, {255'd0, |exp});
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_raddr = a;
        #1;
        check_vec(tag, {224'd0, cfg_rdata}, {224'd0, exp});
    endtask

    // drive at a falling edge, sample just after the next rising edge
    task automatic step(string tag, logic [255:0] v, logic [255:0] exp);
        @(negedge clk);
        din = v;
        @(posedge clk);
        #1;
        check_evt(tag, exp);
    endtask

    function automatic logic [255:0] pat_rise_all();
        logic [255:0] e = '1;
        e[1] = 1'b0; e[3] = 1'b0;
        for (int i = 240; i < 256; i++) e[i] = 1'b0;
        return e;
    endfunction

    function automatic logic [255:0] pat_fall_all();
        logic [255:0] e = '0;
        e[1] = 1'b1; e[2] = 1'b1;
        for (int i = 240; i < 256; i++) e[i] = 1'b1;
        return e;
    endfunction

    task automatic t_reset();
        check_evt("R1 reset events", '0);
        rd_chk("R1 ctrl word 0", 6'd0, 32'h0);
        rd_chk("R1 ctrl word 15", 6'd15, 32'h0);
        rd_chk("R1 mask word 7", 6'd23, 32'h0);
        rd_chk("R1 index", 6'd24, 32'h0);
    endtask

    task automatic t_rise();
        step("R2 rise on all", '1, '1);
        step("R2 steady high", '1, '0);
        step("R2 fall ignored", '0, '0);
    endtask

    task automatic t_packed();
        wr(6'd0, 32'h0000_00E4);   // ch0 rise, ch1 fall, ch2 both, ch3 off
        wr(6'd15, 32'h5555_5555);  // ch240..255 fall
        rd_chk("R7 ctrl word 0", 6'd0, 32'h0000_00E4);
        rd_chk("R7 ctrl word 15", 6'd15, 32'h5555_5555);
        step("R7 R3 R4 R5 rising input", '1, pat_rise_all());
        step("R7 R3 R4 R5 falling input", '0, pat_fall_all());
    endtask

    task automatic t_mask();
        logic [255:0] e = pat_rise_all();
        wr(6'd17, 32'h0000_00FF);  // ch32..39 masked
        rd_chk("R8 mask word 1", 6'd17, 32'h0000_00FF);
        for (int i = 32; i < 40; i++) e[i] = 1'b0;
        step("R6 R8 masked rise", '1, e);
        step("R6 masked fall", '0, pat_fall_all());
    endtask

    task automatic t_index();
        logic [255:0] e = pat_rise_all();
        logic [255:0] f = pat_fall_all();
        wr(6'd24, 32'd100);
        rd_chk("R9 index readback", 6'd24, 32'd100);
        wr(6'd25, 32'd1);          // ch100 -> fall
        rd_chk("R9 sel ctrl readback", 6'd25, 32'd1);
        rd_chk("R9 ctrl word 6", 6'd6, 32'h0000_0100);
        rd_chk("R9 neighbour word 5", 6'd5, 32'h0);
        wr(6'd24, 32'd200);
        wr(6'd26, 32'd1);          // ch200 masked
        rd_chk("R9 sel mask readback", 6'd26, 32'd1);
        rd_chk("R9 mask word 6", 6'd22, 32'h0000_0100);
        rd_chk("R9 mask word 1 kept", 6'd17, 32'h0000_00FF);
        for (int i = 32; i < 40; i++) e[i] = 1'b0;
        e[100] = 1'b0; e[200] = 1'b0;
        f[100] = 1'b1;
        step("R9 indexed rise", '1, e);
        step("R9 indexed fall", '0, f);
    endtask

    task automatic t_clear();
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd27; cfg_wdata = 32'd1; din = '1;
        @(negedge clk);
        cfg_we = 1'b0;
        check_evt("R11 first cycle after clear", '0);
        @(negedge clk);
        check_evt("R11 second cycle after clear", '0);
        rd_chk("R11 ctrl word 0 cleared", 6'd0, 32'h0);
        rd_chk("R11 ctrl word 15 cleared", 6'd15, 32'h0);
        rd_chk("R11 mask word 1 cleared", 6'd17, 32'h0);
        rd_chk("R11 index cleared", 6'd24, 32'h0);
    endtask

    task automatic t_no_idx();
        wr(6'd25, 32'd3);
        wr(6'd26, 32'd1);
        rd_chk("R10 ctrl word 0 unchanged", 6'd0, 32'h0);
        rd_chk("R10 mask word 0 unchanged", 6'd16, 32'h0);
        step("R10 fall under default rise", '0, '0);
        step("R10 ch0 still live", '1, '1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_rise();
        t_packed();
        t_mask();
        t_index();
        t_clear();
        t_no_idx();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule